// File: doc/BRIEF.md
# Sampling Margin Error Detector

This block judges whether a data bus is being captured with enough setup and hold slack. It keeps a sliding window of oversampled copies of the bus, one new copy per clock. When a capture strobe arrives it takes three copies from that window. The real sample sits at the window centre. An early probe sits a programmable number of taps before it, and a late probe sits the same number of taps after it. Each probe is then compared with the real sample.

A disagreement does not mean the captured word is wrong. It means the data edge falls closer to the capture point than the programmed margin allows. If the early probe disagrees, the data settled too late, and the block reports a setup shortfall. If the late probe disagrees, the data changed too soon, and the block reports a hold shortfall.

The error interrupt is sticky until software-side logic clears it. A one-cycle done pulse follows every enabled check, so a controller can step through delay or margin settings and read the verdict after each one.

Top module: `smd_margin_detector`

## Requirements
- R1: Every clock shifts `din_i` into tap 0 of a window of 2*MAX_M+1 taps (MAX_M = 2^MARGIN_W-1, 15 by default), and older copies move to higher indices. When a check runs with margin m, the real sample is tap MAX_M, the early probe is tap MAX_M+m and the late probe is tap MAX_M-m.
- R2: When both probes equal the real sample in every bit, the check raises no error and leaves `err_irq_o` low.
- R3: When the early probe differs from the real sample in any bit, the check sets `err_irq_o` and sets `err_setup_o` to 1, which means a setup shortfall.
- R4: When only the late probe differs from the real sample, the check sets `err_irq_o` and sets `err_setup_o` to 0, which means a hold shortfall.
- R5: When both probes differ from the real sample, the check reports a setup shortfall (`err_setup_o` = 1).
- R6: `err_irq_o` stays high across later error-free checks until `irq_clr_i` is high at a clock edge. That edge lowers it, unless R7 applies.
- R7: When a failing check and `irq_clr_i` fall on the same edge, `err_irq_o` ends high.
- R8: `err_setup_o` reflects the most recent failing check, and error-free checks leave it unchanged.
- R9: A strobe with margin 0 performs no check. It gives no done pulse and no error, and it leaves both error outputs unchanged.
- R10: A strobe with nonzero margin, seen at a clock edge, makes `chk_done_o` high for exactly the following cycle. The error outputs of that check are valid in that same cycle.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | DATA_W | Data lane, sampled every clock into the tap window |
| smp_stb_i | input | 1 | Real sampling instant; runs a check on the current window |
| margin_i | input | MARGIN_W | Probe distance in taps; 0 disables checking |
| irq_clr_i | input | 1 | Write-one-to-clear for the error interrupt |
| err_irq_o | output | 1 | Sticky margin-shortfall interrupt |
| err_setup_o | output | 1 | Kind of the latest error: 1 setup, 0 hold |
| chk_done_o | output | 1 | One-cycle pulse after each enabled check |

## Verification
The bench builds the block with its default parameters: an 8-bit lane and a 4-bit margin, which give a 31-tap window. With that window the full margin of 15 puts the probes on the outermost taps 0 and 30, so the bench can test the window edges as well as the smallest margin of 1, which sits next to the centre. Because the lane is 8 bits wide, the bench can also check that a one-bit difference counts as a mismatch, and can build a centre-only glitch that makes both probes disagree at once.

// File: rtl/smd_pkg.sv
package smd_pkg;

    typedef struct packed {
        logic irq;
        logic setup;
        logic done;
    } smd_status_t;

endpackage

// File: rtl/smd_tap_window.sv
module smd_tap_window #(
    parameter int DATA_W = 8,
    parameter int TAPS   = 31
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DATA_W-1:0]             din_i,
    output logic [TAPS-1:0][DATA_W-1:0]   win_o
);

    logic [TAPS-1:0][DATA_W-1:0] win_d, win_q;

    // newest copy enters at index 0, older copies drift upward
    always_comb begin
        win_d = {win_q[TAPS-2:0], din_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_o = win_q;

endmodule

// File: rtl/smd_margin_cmp.sv
module smd_margin_cmp #(
    parameter int DATA_W   = 8,
    parameter int MARGIN_W = 4,
    localparam int MAX_M   = (1 << MARGIN_W) - 1,
    localparam int TAPS    = 2 * MAX_M + 1,
    localparam int IDX_W   = $clog2(TAPS)
) (
    input  logic [TAPS-1:0][DATA_W-1:0] win_i,
    input  logic [MARGIN_W-1:0]         margin_i,
    output logic                        active_o,
    output logic                        setup_miss_o,
    output logic                        hold_miss_o
);

    logic [IDX_W-1:0]  early_idx, late_idx;
    logic [DATA_W-1:0] real_s, early_s, late_s;
    logic [DATA_W-1:0] early_diff, late_diff;

    always_comb begin
        early_idx = IDX_W'(MAX_M) + IDX_W'(margin_i);
        late_idx  = IDX_W'(MAX_M) - IDX_W'(margin_i);
        real_s    = win_i[MAX_M];
        early_s   = win_i[early_idx];
        late_s    = win_i[late_idx];
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign early_diff[g] = early_s[g] ^ real_s[g];
        assign late_diff[g]  = late_s[g]  ^ real_s[g];
    end

    assign active_o     = (margin_i != '0);
    assign setup_miss_o = active_o && (|early_diff);
    assign hold_miss_o  = active_o && (|late_diff);

endmodule

// File: rtl/smd_margin_detector.sv
module smd_margin_detector
    import smd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MARGIN_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   din_i,
    input  logic                smp_stb_i,
    input  logic [MARGIN_W-1:0] margin_i,
    input  logic                irq_clr_i,
    output logic                err_irq_o,
    output logic                err_setup_o,
    output logic                chk_done_o
);

    localparam int MAX_M = (1 << MARGIN_W) - 1;
    localparam int TAPS  = 2 * MAX_M + 1;

    logic [TAPS-1:0][DATA_W-1:0] win;
    logic active, setup_miss, hold_miss;
    smd_status_t st_d, st_q;

    smd_tap_window #(.DATA_W(DATA_W), .TAPS(TAPS)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .din_i (din_i),
        .win_o (win)
    );

    smd_margin_cmp #(.DATA_W(DATA_W), .MARGIN_W(MARGIN_W)) u_cmp (
        .win_i        (win),
        .margin_i     (margin_i),
        .active_o     (active),
        .setup_miss_o (setup_miss),
        .hold_miss_o  (hold_miss)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (irq_clr_i) st_d.irq = 1'b0;
        if (smp_stb_i && active) begin
            st_d.done = 1'b1;
            if (setup_miss || hold_miss) begin
                st_d.irq   = 1'b1;        // a new error outranks a clear
                st_d.setup = setup_miss;  // setup wins when both disagree
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_irq_o   = st_q.irq;
    assign err_setup_o = st_q.setup;
    assign chk_done_o  = st_q.done;

endmodule

// File: rtl/smd_margin_detector_chk.sv
module smd_margin_detector_chk #(
    parameter int MARGIN_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_stb_i,
    input logic [MARGIN_W-1:0] margin_i,
    input logic                irq_clr_i,
    input logic                err_irq_o,
    input logic                err_setup_o,
    input logic                chk_done_o
);

    // R10
    done_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done_o |-> $past(smp_stb_i && (margin_i != '0)));

    // R9
    zero_margin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb_i && (margin_i == '0)) |=> (!chk_done_o && $stable(err_irq_o) && $stable(err_setup_o)));

    // R6
    irq_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_irq_o) |-> $past(irq_clr_i));

    // R6
    clr_lowers_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !smp_stb_i) |=> !err_irq_o);

    // R8
    type_moves_on_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_setup_o) |-> ($past(smp_stb_i && (margin_i != '0)) && err_irq_o));

    // R2
    irq_rise_on_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq_o) |-> (chk_done_o && $past(smp_stb_i)));

endmodule

bind smd_margin_detector smd_margin_detector_chk #(.MARGIN_W(MARGIN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_stb_i   (smp_stb_i),
    .margin_i    (margin_i),
    .irq_clr_i   (irq_clr_i),
    .err_irq_o   (err_irq_o),
    .err_setup_o (err_setup_o),
    .chk_done_o  (chk_done_o)
);

// File: tb/smd_margin_detector_bench.sv
module smd_margin_detector_bench;

    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int MW     = 4;
    localparam int TAPS   = 31;
    localparam logic [DW-1:0] OLDV = 8'h3C;
    localparam logic [DW-1:0] NEWV = 8'hC3;

    // {margin[12:9], edge_pos[8:3], done[2], irq[1], setup[0]}
    // taps below edge_pos hold NEWV, the rest OLDV
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {4'd4,  6'd0,  1'b1, 1'b0, 1'b0},   // R2 flat
        {4'd4,  6'd25, 1'b1, 1'b0, 1'b0},   // R2 edge beyond early probe
        {4'd4,  6'd18, 1'b1, 1'b1, 1'b1},   // R3
        {4'd4,  6'd13, 1'b1, 1'b1, 1'b0},   // R4
        {4'd15, 6'd31, 1'b1, 1'b0, 1'b0},   // R1 outer taps clean
        {4'd15, 6'd30, 1'b1, 1'b1, 1'b1},   // R1 R3 tap 30
        {4'd15, 6'd1,  1'b1, 1'b1, 1'b0},   // R1 R4 tap 0
        {4'd1,  6'd16, 1'b1, 1'b1, 1'b1},   // R3 margin 1
        {4'd1,  6'd15, 1'b1, 1'b1, 1'b0},   // R4 margin 1
        {4'd1,  6'd14, 1'b1, 1'b0, 1'b0},   // R2 margin 1
        {4'd1,  6'd17, 1'b1, 1'b0, 1'b0},   // R2 margin 1
        {4'd0,  6'd16, 1'b0, 1'b0, 1'b0}    // R9
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic stb = 1'b0;
    logic [MW-1:0] margin = '0;
    logic clr = 1'b0;
    logic err_irq, err_setup, chk_done;
    int tests = 0;
    int fails = 0;

    always #(PERIOD/2) clk = ~clk;

    smd_margin_detector #(.DATA_W(DW), .MARGIN_W(MW)) u_smd_margin_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .din_i       (din),
        .smp_stb_i   (stb),
        .margin_i    (margin),
        .irq_clr_i   (clr),
        .err_irq_o   (err_irq),
        .err_setup_o (err_setup),
        .chk_done_o  (chk_done)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {irq,setup,done} actual %b expected %b", req, act, exp);
        end
    endtask

    // fill the window, then strobe; returns at the negedge after the check edge
    task automatic run(input logic [MW-1:0] m, input int pos,
                       input logic [DW-1:0] ov, input logic [DW-1:0] nv,
                       input bit glitch, input bit clr_at_stb);
        margin = m;
        for (int k = TAPS - 1; k >= 0; k--) begin
            @(negedge clk);
            if (glitch) din = (k == 15) ? nv : ov;
            else        din = (k < pos) ? nv : ov;
        end
        @(negedge clk);
        stb = 1'b1;
        clr = clr_at_stb;
        @(negedge clk);
        stb = 1'b0;
        clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11", {err_irq, err_setup, chk_done}, 3'b000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pulse_clr();
            run(VEC[i][12:9], int'(VEC[i][8:3]), OLDV, NEWV, 1'b0, 1'b0);
            if (VEC[i][1])
                check($sformatf("R3/R4 vec%0d", i), {err_irq, err_setup, chk_done}, {VEC[i][1], VEC[i][0], VEC[i][2]});
            else
                check($sformatf("R2/R9 vec%0d", i), {err_irq, 1'b0, chk_done}, {1'b0, 1'b0, VEC[i][2]});
        end

        // R10 pulse lasts one cycle
        @(negedge clk);
        check("R10", {1'b0, 1'b0, chk_done}, 3'b000);

        // R5 centre glitch: both probes disagree
        pulse_clr();
        run(4'd3, 0, OLDV, NEWV, 1'b1, 1'b0);
        check("R5", {err_irq, err_setup, chk_done}, 3'b111);

        // R6 R8 clean check without clear keeps irq and type
        run(4'd3, 0, OLDV, NEWV, 1'b0, 1'b0);
        check("R6 R8 sticky", {err_irq, err_setup, chk_done}, 3'b111);

        // R8 later hold error replaces type; single-bit difference (R1)
        run(4'd2, 14, 8'h3C, 8'h7C, 1'b0, 1'b0);
        check("R8 R1 hold one bit", {err_irq, err_setup, chk_done}, 3'b101);

        // R9 margin 0 with glitch leaves state alone
        run(4'd0, 0, OLDV, NEWV, 1'b1, 1'b0);
        check("R9 state kept", {err_irq, err_setup, chk_done}, 3'b100);

        // R6 clear alone lowers irq, type kept
        pulse_clr();
        check("R6 clear", {err_irq, err_setup, chk_done}, 3'b000);

        // R7 error and clear on same edge
        run(4'd5, 19, OLDV, NEWV, 1'b0, 1'b1);
        check("R7", {err_irq, err_setup, chk_done}, 3'b111);

        // R11 reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset", {err_irq, err_setup, chk_done}, 3'b000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule